// File: doc/BRIEF.md
# Multiprocessor-Addressed UART Transceiver

This block is a full-duplex asynchronous serial transceiver for a shared bus on which one master addresses many stations. Every character carries a ninth payload bit, the multiprocessor (MP) bit, placed after the eight data bits. A value of 1 marks the character as a station ID and a value of 0 marks it as ordinary data. A station that is not addressed sets a filter bit. The receiver then drops every data character silently, with no status flag raised. The first ID character clears the filter in hardware and is received normally. Software then reads the ID and decides whether to stay awake.

Software sees four registers on a simple write/read port: control, transmit data, receive data and status. There is no valid/ready stream at the edge. Back-pressure is carried by the flags. The transmitter loads a new character only after software clears the transmit-empty flag. A received character that finds the receive-full flag still set is not stored, and it raises the overrun flag instead. Bit timing comes from an external baud tick at 16 times the bit rate. Each bit lasts 16 ticks.

Register map (2-bit address):
- Address 0, control: bit0 transmit enable, bit1 receive enable, bit2 filter enable, bit3 transmitted MP bit.
- Address 1, transmit data.
- Address 2, receive data (read only).
- Address 3, status: bit0 transmit-empty, bit1 receive-full, bit2 framing error, bit3 overrun, bit4 MP bit of the last stored character (read only).

Status bits 0 to 3 are cleared by writing 0 to them. Writing 1 to them leaves them unchanged.

Top module: `mp_uart`

## Requirements
- R1: After reset, control reads 0x00, receive data reads 0x00, status reads 0x01 and the serial output is high.
- R2: A transmitted frame is, in order: a low start bit, the 8 data bits LSB first, the MP bit taken from control bit3, and a high stop bit. Each bit lasts 16 baud ticks.
- R3: A frame is sent only while transmit is enabled and after software has cleared status bit0 by writing 0 to it. Loading the character sets bit0 back to 1. Writing transmit data alone leaves the line idle high.
- R4: While transmit enable is 0, status bit0 reads 1, even right after a write of 0 to it, and no frame is sent.
- R5: Reception starts on a low level of the input while receive enable is 1. The start is confirmed only if the line is still low 8 ticks later. A low pulse shorter than that is rejected. While receive enable is 0, the input is ignored.
- R6: A completed, accepted frame puts its data in the receive data register. It also sets status bit1 and copies its MP bit to status bit4.
- R7: An accepted frame whose stop bit is sampled low sets status bit2.
- R8: An accepted frame that completes while status bit1 is already 1 sets status bit3. It leaves receive data and status bit4 unchanged.
- R9: While control bit2 is 1, a frame with MP bit 0 is discarded. It changes no flag and no data, even with a bad stop bit, and control bit2 stays 1.
- R10: A frame with MP bit 1 that arrives while control bit2 is 1 clears control bit2. That same frame is then received under R6 to R8.
- R11: Clearing receive enable leaves status bits 1 to 4 unchanged.
- R12: Writing status clears exactly the bits 0 to 3 written as 0. Bits written as 1 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| txd_o | output | 1 | Serial output, idle high |
| rxd_i | input | 1 | Serial input, asynchronous |

## Verification
A filter that fails to drop a data frame shows up as a set receive-full or framing-error flag. It appears one clock after that frame's stop-bit sample. A filter that never releases leaves control bit2 set after an ID frame and keeps receive-full low. A receive sampler that is off by a bit or misses a shift corrupts the stored byte or its MP bit on the very next frame. The full sweep of all 256 receive values therefore exposes it within one character time. A transmit counter fault changes the bit pattern seen at bit centres within one frame. A wrong empty-flag gate shows up either as a frame sent without the clear or as status bit0 reading 0 with transmit disabled.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_TXD  = 2'd1,
    A_RXD  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  // control register layout, MSB first (bits 3..0)
  typedef struct packed {
    logic tx_mpb;
    logic filt_en;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/mp_uart_tx.sv
module mp_uart_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpb_i,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int OVS_W   = $clog2(OVS);
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [OVS_W-1:0]   ovs_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      ovs_q   <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load_i && !busy_q) begin
      shreg_q <= {1'b1, mpb_i, data_i, 1'b0};
      ovs_q   <= '0;
      left_q  <= CNT_W'(FRAME_W);
      busy_q  <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (ovs_q == OVS_W'(OVS - 1)) begin
        ovs_q   <= '0;
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        left_q  <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        ovs_q <= ovs_q + 1'b1;
      end
    end
  end

  assign txd_o  = busy_q ? shreg_q[0] : 1'b1;
  assign busy_o = busy_q;

  // R2
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(txd_o));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              stop_o
);
  localparam int OVS_W  = $clog2(OVS);
  localparam int SH_W   = DATA_W + 1;
  localparam int BCNT_W = $clog2(SH_W + 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         st_q;
  logic [OVS_W-1:0]  ovs_q;
  logic [BCNT_W-1:0] bit_q;
  logic [SH_W-1:0]   sh_q;
  logic              done_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end
  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      ovs_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q <= RX_IDLE;
      end else begin
        unique case (st_q)
          RX_IDLE: begin
            if (!rx_s) begin
              st_q  <= RX_START;
              ovs_q <= '0;
            end
          end
          RX_START: begin
            if (tick_i) begin
              if (ovs_q == OVS_W'(OVS / 2 - 1)) begin
                ovs_q <= '0;
                bit_q <= '0;
                st_q  <= rx_s ? RX_IDLE : RX_BITS;
              end else begin
                ovs_q <= ovs_q + 1'b1;
              end
            end
          end
          RX_BITS: begin
            if (tick_i) begin
              if (ovs_q == OVS_W'(OVS - 1)) begin
                ovs_q <= '0;
                if (bit_q == BCNT_W'(SH_W)) begin
                  stop_q <= rx_s;
                  done_q <= 1'b1;
                  st_q   <= RX_IDLE;
                end else begin
                  sh_q  <= {rx_s, sh_q[SH_W-1:1]};
                  bit_q <= bit_q + 1'b1;
                end
              end else begin
                ovs_q <= ovs_q + 1'b1;
              end
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q[DATA_W-1:0];
  assign mpb_o  = sh_q[DATA_W];
  assign stop_o = stop_q;

  // R11
  rx_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == RX_IDLE) && !done_o);

  // R5
  start_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_IDLE) && $past(st_q) == RX_START |-> $past(!tick_i) == 1'b0 || !en_i || $past(!en_i));
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              txd_o,
  input  logic              rxd_i
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] txd_q, rxd_q;
  logic              tde_q, rdf_q, fer_q, ovr_q, rmpb_q;
  logic              tx_busy, tx_load;
  logic              rx_done, rx_mpb, rx_stop;
  logic [DATA_W-1:0] rx_data;
  logic              rx_accept;
  logic              wr_ctrl, wr_txd, wr_stat;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_txd    = wr_en_i && (wr_addr_i == A_TXD);
  assign wr_stat   = wr_en_i && (wr_addr_i == A_STAT);
  assign tx_load   = ctrl_q.tx_en && !tde_q && !tx_busy;
  assign rx_accept = rx_done && (!ctrl_q.filt_en || rx_mpb);

  mp_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .load_i (tx_load),
    .data_i (txd_q),
    .mpb_i  (ctrl_q.tx_mpb),
    .busy_o (tx_busy),
    .txd_o  (txd_o)
  );

  mp_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) rx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.rx_en),
    .tick_i (baud_tick_i),
    .rxd_i  (rxd_i),
    .done_o (rx_done),
    .data_o (rx_data),
    .mpb_o  (rx_mpb),
    .stop_o (rx_stop)
  );

  // control and transmit data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      txd_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_txd)  txd_q  <= wr_data_i;
      if (rx_done && ctrl_q.filt_en && rx_mpb) ctrl_q.filt_en <= 1'b0;
    end
  end

  // transmit-empty flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tde_q <= 1'b1;
    else if (!ctrl_q.tx_en || tx_load)    tde_q <= 1'b1;
    else if (wr_stat && !wr_data_i[0])    tde_q <= 1'b0;
  end

  // receive flags and data: software clears first, hardware sets win
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_q  <= '0;
      rdf_q  <= 1'b0;
      fer_q  <= 1'b0;
      ovr_q  <= 1'b0;
      rmpb_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        if (!wr_data_i[1]) rdf_q <= 1'b0;
        if (!wr_data_i[2]) fer_q <= 1'b0;
        if (!wr_data_i[3]) ovr_q <= 1'b0;
      end
      if (rx_accept) begin
        if (rdf_q) begin
          ovr_q <= 1'b1;
        end else begin
          rxd_q  <= rx_data;
          rdf_q  <= 1'b1;
          rmpb_q <= rx_mpb;
          if (!rx_stop) fer_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: rd_data_o[CTRL_W-1:0] = ctrl_q;
      A_TXD:  rd_data_o = txd_q;
      A_RXD:  rd_data_o = rxd_q;
      A_STAT: rd_data_o[4:0] = {rmpb_q, ovr_q, fer_q, rdf_q, tde_q | ~ctrl_q.tx_en};
      default: rd_data_o = '0;
    endcase
  end

  // R9
  filt_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && ctrl_q.filt_en && !rx_mpb && !wr_en_i)
      |=> $stable({rdf_q, fer_q, ovr_q, rmpb_q, rxd_q}) && ctrl_q.filt_en);

  // R10
  filt_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && ctrl_q.filt_en && rx_mpb) |=> !ctrl_q.filt_en && (rdf_q || ovr_q));

  // R8
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rdf_q && !ctrl_q.filt_en && !wr_en_i) |=> ovr_q && $stable(rxd_q));

  // R3
  tx_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> $past(ctrl_q.tx_en) && !$past(tde_q));
endmodule

// File: tb/mp_uart_tb_top.sv
module mp_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       txd;
  logic       rxd = 1'b1;
  int checks = 0;
  int fails  = 0;
  localparam int BITCLK = 32;  // 16 ticks, one tick every 2 clocks

  always #5 clk = ~clk;
  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  mp_uart dut_i (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .txd_o(txd), .rxd_i(rxd)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic mpb, input logic stop);
    logic [10:0] f;
    f = {stop, mpb, d, 1'b0};
    for (int b = 0; b < 11; b++) begin
      @(negedge clk);
      rxd = f[b];
      repeat (BITCLK - 1) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic mpb);
    logic [10:0] got, exp;
    int to;
    exp = {1'b1, mpb, d, 1'b0};
    wr(2'd1, d);
    wr(2'd0, {4'b0, mpb, 3'b001});
    wr(2'd3, 8'hFE);
    to = 0;
    while (txd && to < 200) begin @(negedge clk); to++; end
    repeat (BITCLK / 2) @(negedge clk);
    for (int b = 0; b < 11; b++) begin
      got[b] = txd;
      if (b < 10) repeat (BITCLK) @(negedge clk);
    end
    // R2: bit-centre samples form start, data LSB first, MP, stop
    chk(got == exp, "R2", {5'b0, got}, {5'b0, exp});
    repeat (BITCLK) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, s;
    bit seen_low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    rd(2'd3, v); chk(v == 8'h01, "R1 stat", v, 8'h01);
    rd(2'd2, v); chk(v == 8'h00, "R1 rxd", v, 8'h00);
    chk(txd == 1'b1, "R1 txd", txd, 1);

    // R4: disabled transmitter, cleared empty flag still reads 1, no frame
    wr(2'd1, 8'h5A);
    wr(2'd3, 8'hFE);
    rd(2'd3, v); chk(v[0] == 1'b1, "R4 tde", v, 8'h01);
    seen_low = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!txd) seen_low = 1; end
    chk(!seen_low, "R4 idle", seen_low, 0);

    // R3: enabled but flag not cleared -> no frame
    wr(2'd0, 8'h01);
    wr(2'd1, 8'hA5);
    seen_low = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!txd) seen_low = 1; end
    chk(!seen_low, "R3 no start", seen_low, 0);
    rd(2'd3, v); chk(v[0] == 1'b1, "R3 tde", v, 8'h01);

    // R2/R3 transmit sweep
    for (int i = 0; i < 16; i++) begin
      tx_frame(8'(i * 37 + 3), 1'(i));
      rd(2'd3, v); chk(v[0] == 1'b1, "R3 tde after load", v, 8'h01);
    end
    wr(2'd0, 8'h00);

    // R6 receive sweep over every byte value
    wr(2'd0, 8'h02);
    for (int d = 0; d < 256; d++) begin
      rx_frame(8'(d), 1'((d >> 3) & 1), 1'b1);
      rd(2'd2, v); chk(v == 8'(d), "R6 data", v, 8'(d));
      s = {3'b0, 1'((d >> 3) & 1), 4'b0011};
      rd(2'd3, v); chk(v == s, "R6 stat", v, s);
      wr(2'd3, 8'hF1);
    end

    // R7 framing error
    rx_frame(8'h3C, 1'b0, 1'b0);
    rd(2'd2, v); chk(v == 8'h3C, "R7 data", v, 8'h3C);
    rd(2'd3, v); chk(v == 8'h07, "R7 stat", v, 8'h07);
    wr(2'd3, 8'hF1);

    // R9 filtered data frame with bad stop: nothing changes
    wr(2'd0, 8'h06);
    rx_frame(8'h55, 1'b0, 1'b0);
    rd(2'd3, v); chk(v == 8'h01, "R9 stat", v, 8'h01);
    rd(2'd2, v); chk(v == 8'h3C, "R9 data", v, 8'h3C);
    rd(2'd0, v); chk(v == 8'h06, "R9 ctrl", v, 8'h06);

    // R10 ID frame releases filter and is stored
    rx_frame(8'hA3, 1'b1, 1'b1);
    rd(2'd0, v); chk(v == 8'h02, "R10 ctrl", v, 8'h02);
    rd(2'd2, v); chk(v == 8'hA3, "R10 data", v, 8'hA3);
    rd(2'd3, v); chk(v == 8'h13, "R10 stat", v, 8'h13);

    // R8 overrun
    rx_frame(8'h11, 1'b0, 1'b1);
    rd(2'd2, v); chk(v == 8'hA3, "R8 data", v, 8'hA3);
    rd(2'd3, v); chk(v == 8'h1B, "R8 stat", v, 8'h1B);

    // R11 disable receiver keeps flags; R5 input ignored while disabled
    wr(2'd0, 8'h00);
    rd(2'd3, v); chk(v == 8'h1B, "R11 stat", v, 8'h1B);
    rx_frame(8'h77, 1'b1, 1'b0);
    rd(2'd3, v); chk(v == 8'h1B, "R5 disabled", v, 8'h1B);
    rd(2'd2, v); chk(v == 8'hA3, "R5 disabled data", v, 8'hA3);

    // R12 write-1 keeps, write-0 clears selected bits only
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk(v == 8'h1B, "R12 keep", v, 8'h1B);
    wr(2'd3, 8'hFD);
    rd(2'd3, v); chk(v == 8'h19, "R12 clear rdf", v, 8'h19);
    wr(2'd3, 8'hF1);
    rd(2'd3, v); chk(v == 8'h11, "R12 clear all", v, 8'h11);

    // R5 short low pulse rejected, then a real frame still works
    wr(2'd0, 8'h02);
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (100) @(negedge clk);
    rd(2'd3, v); chk(v[1] == 1'b0, "R5 glitch", v, 8'h11);
    rx_frame(8'hC6, 1'b0, 1'b1);
    rd(2'd2, v); chk(v == 8'hC6, "R5 after glitch", v, 8'hC6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule